// File: doc/BRIEF.md
# Power-Down Sequencer for a Clock Generator

This block controls how a clock generator goes into and comes out of its low-power state. A request arrives on an asynchronous active-low pin. The block first resynchronizes it into the internal CPU clock domain. It then turns off every output clock enable, and does so on a falling edge of that clock. Only after that does it drop the VCO enable, and after the VCO the crystal oscillator enable. When the request is withdrawn, the block restarts the crystal, then the VCO. It then counts a settling interval, measured in reference-clock ticks, and only after that releases the output enables again.

The outputs are plain enables. They feed the output gating cells, the PLL core and the oscillator, none of which are part of this block. The CPU and PCI stop inputs pass through to their gates during normal running. While a power-down is in progress they have no effect. A request that is dropped partway through the entry sequence does not cut that sequence short. The sequence runs to the sleep state and the exit starts on the next cycle. Reset starts the block in the middle of a wake-up, so the settling interval also applies at power-on.

Top module: `pd_sequencer`

## Requirements
- R1: While reset is high and right after it, cpu_clk_en, pci_clk_en, free_clk_en and vco_en are 0 and xtal_en is 1. The block then wakes with no request pending.
- R2: pd_n passes through SYNC_STAGES flip-flops. With 2 stages, a fall of pd_n between rising edges P0 and P1 leaves the output enables high through P2 and turns them low after edge P3.
- R3: The output enables fall on the falling clock edge that follows the rising edge at which the sequence leaves the running state. vco_en falls on the next rising edge, and xtal_en falls one rising edge after vco_en.
- R4: vco_en low implies that every output enable is low, and xtal_en low implies that vco_en is low.
- R5: Outside the running state, cpu_clk_en and pci_clk_en stay 0 whatever the values of cpu_stop_n and pci_stop_n.
- R6: In the running state, free_clk_en is 1, cpu_clk_en equals cpu_stop_n and pci_clk_en equals pci_stop_n.
- R7: On exit, xtal_en rises first and vco_en rises one cycle later. The output enables rise on the falling edge after STABLE_TICKS ref_tick pulses have been counted with vco_en high.
- R8: If pd_n returns high during the entry sequence, the entry still completes, so xtal_en goes low for at least one cycle. The exit sequence then follows without further stimulus.
- R9: The wake latency from the rise of pd_n to free_clk_en high is bounded: at most SYNC_STAGES + 3 cycles plus the time needed to collect STABLE_TICKS ref_tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| ref_tick | input | 1 | One-cycle strobe per reference-clock period |
| cpu_stop_n | input | 1 | Active-low CPU clock stop |
| pci_stop_n | input | 1 | Active-low PCI clock stop |
| cpu_clk_en | output | 1 | Gate enable for stoppable CPU clocks |
| pci_clk_en | output | 1 | Gate enable for stoppable PCI clocks |
| free_clk_en | output | 1 | Gate enable for free-running, reference and 48 MHz clocks |
| vco_en | output | 1 | PLL VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The hardest case to reach from the ports is a request that disappears while the entry sequence is still running. The sleep state is then occupied for a single cycle and the exit begins at once. The stimulus produces this by pulling pd_n low for exactly one clock period, so the synchronized request is high for just one cycle. The half-cycle offset between the gating flop and the VCO shutdown is another corner. To catch it, the outputs are sampled both before and after the falling edge that follows the sequencer's state change.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [2:0] {
        PS_RUN      = 3'd0,
        PS_GATE     = 3'd1,
        PS_VCO_OFF  = 3'd2,
        PS_XTAL_OFF = 3'd3,
        PS_SLEEP    = 3'd4,
        PS_XTAL_ON  = 3'd5,
        PS_SETTLE   = 3'd6
    } pd_state_e;

    typedef struct packed {
        logic outputs;
        logic vco;
        logic xtal;
    } pd_ctl_t;

    function automatic pd_ctl_t ctl_of(pd_state_e st);
        pd_ctl_t c;
        c.outputs = (st == PS_RUN);
        c.vco     = (st == PS_RUN) || (st == PS_GATE) || (st == PS_SETTLE);
        c.xtal    = (st != PS_XTAL_OFF) && (st != PS_SLEEP);
        return c;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pd_wake_timer.sv
module pd_wake_timer #(
    parameter int unsigned TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = pdseq_pkg::cnt_width(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    assign done = run && tick && (cnt == LAST);
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pdseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pd_req,
    input  logic      settle_done,
    output pd_state_e state
);
    pd_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PS_RUN:      if (pd_req) nxt = PS_GATE;
            PS_GATE:     nxt = PS_VCO_OFF;
            PS_VCO_OFF:  nxt = PS_XTAL_OFF;
            PS_XTAL_OFF: nxt = PS_SLEEP;
            PS_SLEEP:    if (!pd_req) nxt = PS_XTAL_ON;
            PS_XTAL_ON:  nxt = PS_SETTLE;
            PS_SETTLE:   if (settle_done) nxt = PS_RUN;
            default:     nxt = PS_XTAL_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_XTAL_ON;
        else     state <= nxt;
    end
endmodule

// File: rtl/pd_out_gate.sv
module pd_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic allow,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    output logic cpu_clk_en,
    output logic pci_clk_en,
    output logic free_clk_en
);
    logic gate_q;

    // Updated on the falling edge so outputs stop low without a runt high pulse.
    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= allow;
    end

    assign free_clk_en = gate_q;
    assign cpu_clk_en  = gate_q & cpu_stop_n;
    assign pci_clk_en  = gate_q & pci_stop_n;
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import pdseq_pkg::*;
#(
    parameter int          SYNC_STAGES  = 2,
    parameter int unsigned STABLE_TICKS = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    input  logic ref_tick,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    output logic cpu_clk_en,
    output logic pci_clk_en,
    output logic free_clk_en,
    output logic vco_en,
    output logic xtal_en
);
    logic      pd_n_sync;
    logic      settle_done;
    pd_state_e state;
    pd_ctl_t   ctl;

    pd_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pd_n),
        .sync_out (pd_n_sync)
    );

    pd_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .pd_req      (!pd_n_sync),
        .settle_done (settle_done),
        .state       (state)
    );

    pd_wake_timer #(.TICKS(STABLE_TICKS)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .run  (state == PS_SETTLE),
        .tick (ref_tick),
        .done (settle_done)
    );

    assign ctl     = ctl_of(state);
    assign vco_en  = ctl.vco;
    assign xtal_en = ctl.xtal;

    pd_out_gate gate_i (
        .clk         (clk),
        .rst         (rst),
        .allow       (ctl.outputs),
        .cpu_stop_n  (cpu_stop_n),
        .pci_stop_n  (pci_stop_n),
        .cpu_clk_en  (cpu_clk_en),
        .pci_clk_en  (pci_clk_en),
        .free_clk_en (free_clk_en)
    );
endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic cpu_clk_en,
    input logic pci_clk_en,
    input logic free_clk_en,
    input logic vco_en,
    input logic xtal_en
);
    // R4
    vco_off_outputs_low_chk: assert property (@(posedge clk) disable iff (rst)
        !vco_en |-> (!cpu_clk_en && !pci_clk_en && !free_clk_en));

    // R4
    xtal_off_vco_off_chk: assert property (@(posedge clk) disable iff (rst)
        !xtal_en |-> !vco_en);

    // R3
    xtal_after_vco_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xtal_en) |-> !$past(vco_en));

    // R7
    vco_after_xtal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vco_en) |-> (xtal_en && $past(xtal_en)));

    // R7
    release_needs_pll_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(free_clk_en) |-> ($past(vco_en) && $past(xtal_en)));
endmodule

bind pd_sequencer pd_sequencer_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cpu_clk_en  (cpu_clk_en),
    .pci_clk_en  (pci_clk_en),
    .free_clk_en (free_clk_en),
    .vco_en      (vco_en),
    .xtal_en     (xtal_en)
);

// File: tb/pd_sequencer_tb_top.sv
`timescale 1ns/1ps
module pd_sequencer_tb_top;
    localparam int STAGES = 2;
    localparam int STABLE = 12;
    localparam int DIV    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_n = 1'b1;
    logic ref_tick = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic cpu_clk_en, pci_clk_en, free_clk_en, vco_en, xtal_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pd_sequencer #(.SYNC_STAGES(STAGES), .STABLE_TICKS(STABLE)) dut_i (
        .clk(clk), .rst(rst), .pd_n(pd_n), .ref_tick(ref_tick),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_clk_en(cpu_clk_en), .pci_clk_en(pci_clk_en),
        .free_clk_en(free_clk_en), .vco_en(vco_en), .xtal_en(xtal_en)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // reference tick generator
    int cyc = 0;
    always begin
        @(posedge clk);
        #2;
        cyc++;
        ref_tick = (cyc % DIV == 0);
    end

    // behavioural reference model: 0 run,1 gate,2 vco off,3 xtal off,4 sleep,5 xtal on,6 settle
    bit s1, s2;
    int mst, mcnt;
    bit mout;
    always @(posedge clk) begin
        if (rst) begin
            s1 <= 1; s2 <= 1; mst <= 5; mcnt <= 0;
        end else begin
            s1 <= pd_n; s2 <= s1;
            case (mst)
                0: if (!s2) mst <= 1;
                1: mst <= 2;
                2: mst <= 3;
                3: mst <= 4;
                4: if (s2) mst <= 5;
                5: begin mst <= 6; mcnt <= 0; end
                default: if (ref_tick) begin
                    if (mcnt == STABLE - 1) begin mst <= 0; mcnt <= 0; end
                    else mcnt <= mcnt + 1;
                end
            endcase
        end
    end
    always @(negedge clk) mout <= rst ? 1'b0 : (mst == 0);

    always begin
        @(posedge clk);
        #6;
        if (!rst && !finished) begin
            chk(cpu_clk_en, mout & cpu_stop_n, "R6 model cpu_clk_en");
            chk(pci_clk_en, mout & pci_stop_n, "R5 model pci_clk_en");
            chk(free_clk_en, mout, "R6 model free_clk_en");
            chk(vco_en, (mst == 0 || mst == 1 || mst == 6), "R3 model vco_en");
            chk(xtal_en, !(mst == 3 || mst == 4), "R7 model xtal_en");
        end
    end

    task automatic step_drive();  @(posedge clk); #2; endtask
    task automatic step_sample(); @(posedge clk); #6; endtask

    task automatic wait_running(input string tag);
        int n = 0;
        int bound = STAGES + 3 + (STABLE + 1) * DIV + 2;
        while (!free_clk_en && n < 400) begin step_sample(); n++; end
        checks++;
        if (n > bound) begin
            errors++;
            $display("FAIL %s wake latency actual=%0d expected<=%0d", tag, n, bound);
        end
    endtask

    initial begin
        repeat (3) step_sample();
        // R1 reset state
        chk(cpu_clk_en, 1'b0, "R1 cpu_clk_en in reset");
        chk(free_clk_en, 1'b0, "R1 free_clk_en in reset");
        chk(vco_en, 1'b0, "R1 vco_en in reset");
        chk(xtal_en, 1'b1, "R1 xtal_en in reset");
        step_drive(); rst = 1'b0;
        step_sample();
        chk(vco_en, 1'b1, "R1 vco restarts after reset");
        chk(free_clk_en, 1'b0, "R1 outputs held during settle");
        wait_running("R9 after reset");
        chk(free_clk_en, 1'b1, "R1 running after reset");

        // R6 stop inputs while running
        step_drive(); cpu_stop_n = 1'b0;
        #4; chk(cpu_clk_en, 1'b0, "R6 cpu stopped");
        chk(pci_clk_en, 1'b1, "R6 pci still running");
        chk(free_clk_en, 1'b1, "R6 free running");
        step_drive(); cpu_stop_n = 1'b1; pci_stop_n = 1'b0;
        #4; chk(pci_clk_en, 1'b0, "R6 pci stopped");
        chk(cpu_clk_en, 1'b1, "R6 cpu running");
        step_drive(); pci_stop_n = 1'b1;

        // R2/R3 entry timing
        step_drive(); pd_n = 1'b0;
        step_sample(); chk(free_clk_en, 1'b1, "R2 after P1");
        step_sample(); chk(free_clk_en, 1'b1, "R2 after P2");
        @(posedge clk); #1;
        chk(free_clk_en, 1'b1, "R3 high before falling edge");
        chk(vco_en, 1'b1, "R3 vco on at gate edge");
        #5; chk(free_clk_en, 1'b0, "R2 low after P3 falling edge");
        chk(cpu_clk_en, 1'b0, "R3 cpu low");
        step_sample(); chk(vco_en, 1'b0, "R3 vco off");
        chk(xtal_en, 1'b1, "R3 xtal still on");
        step_sample(); chk(xtal_en, 1'b0, "R3 xtal off");

        // R5 stop inputs ignored while asleep
        step_drive(); cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        #4; chk(cpu_clk_en, 1'b0, "R5 cpu held asleep");
        chk(pci_clk_en, 1'b0, "R5 pci held asleep");
        step_drive(); cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        #4; chk(cpu_clk_en, 1'b0, "R5 cpu held asleep toggled");
        step_drive(); cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (3) step_sample();
        chk(xtal_en, 1'b0, "R5 still asleep");

        // R7 exit ordering
        step_drive(); pd_n = 1'b1;
        step_sample(); step_sample();
        chk(xtal_en, 1'b0, "R7 xtal off before sync");
        step_sample(); chk(xtal_en, 1'b1, "R7 xtal first");
        chk(vco_en, 1'b0, "R7 vco after xtal");
        step_sample(); chk(vco_en, 1'b1, "R7 vco on");
        chk(free_clk_en, 1'b0, "R7 outputs wait");
        wait_running("R9 exit");
        chk(cpu_clk_en, 1'b1, "R7 released");

        // R8 one-cycle pulse during entry
        begin
            bit saw_low = 1'b0;
            step_drive(); pd_n = 1'b0;
            step_drive(); pd_n = 1'b1;
            for (int i = 0; i < 10; i++) begin
                step_sample();
                if (!xtal_en) saw_low = 1'b1;
            end
            chk(saw_low, 1'b1, "R8 entry completed");
            chk(xtal_en, 1'b1, "R8 exit started");
            wait_running("R8 R9 auto exit");
            chk(free_clk_en, 1'b1, "R8 running again");
        end

        repeat (4) step_sample();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule